// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block holds one single-entry mailbox for each CPU of a multiprocessor. Interrupt messages arrive from an external bus on a valid/ready request port. Each message carries a target CPU number, a 5-bit source id and two 64-bit payload words. If the target mailbox is free, the block raises ready in the same cycle and takes the message. It marks the mailbox busy, stores the source id and both payload words, and one cycle later posts a shared, software-programmable vector to the target CPU. If the mailbox is still busy, ready stays low. The sender then has to retry later, and nothing is stored or posted.

Software reaches the mailboxes through a word-addressed register port, with registers spaced 8 bytes apart. Indexed arrays expose the payload words and status of every mailbox. A set of alias offsets resolves to the mailbox of whichever CPU issues the access, given on the requester-id input. Software frees a mailbox by writing its busy bit to 0.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset every mailbox is free with source and payload zero, the shared vector is 0, and `post_valid`, `reg_rvalid` and `in_ready` are low.
- R2: When `in_valid` is high and the target mailbox is free, `in_ready` is high in that same cycle. The mailbox becomes busy, and on the next cycle `post_valid` is high for exactly one cycle with `post_cpu` equal to the target.
- R3: When `in_valid` is high and the target mailbox is busy, `in_ready` is low, no post follows, and the stored source and payload are unchanged. `in_ready` is never high while `in_valid` is low.
- R4: Payload word 0 of mailbox i reads at offset 0x000 + 8*i, and payload word 1 reads at offset 0x100 + 8*i.
- R5: The status of mailbox i reads at offset 0x200 + 8*i. Bit 5 holds busy, bits 4:0 hold the stored source id, and all other bits read 0.
- R6: A write to a status offset loads busy from write-data bit 5 and ignores every other bit. Writing 0 frees the mailbox so that the next message is accepted. Writing 1 makes it busy so that messages are refused.
- R7: Offsets 0x300 (payload 0), 0x308 (payload 1) and 0x310 (status) act on the mailbox numbered by `reg_cpu`. They behave exactly like the indexed offsets for that mailbox, for both reads and status writes.
- R8: The shared vector register is at offset 0x318. It keeps write-data bits 5:0, reads back zero-extended, and `post_vec` carries its value as it stood in the accepting cycle.
- R9: When a status write and a message target the same mailbox in the same cycle, the write applies first and the message sees the written busy value. A status write to a different mailbox does not affect acceptance.
- R10: Read data appears on `reg_rdata` with `reg_rvalid` high exactly one cycle after a read. Misaligned or unmapped offsets read as 0. Writes to payload or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming interrupt message valid |
| in_cpu | input | 5 | Target CPU of the message |
| in_src | input | 5 | Source id of the message |
| in_data0 | input | 64 | Payload word 0 |
| in_data1 | input | 64 | Payload word 1 |
| in_ready | output | 1 | Message accepted this cycle (low means retry later) |
| post_valid | output | 1 | One-cycle interrupt post to a CPU |
| post_cpu | output | 5 | CPU receiving the post |
| post_vec | output | 6 | Vector delivered with the post |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_cpu | input | 5 | Id of the CPU issuing the access (alias selection) |
| reg_wdata | input | 64 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 64 | Read data |

## Verification
Messages are sent to free mailboxes, to busy ones, and to mailboxes freed or locked by a status write in that same cycle. These cases separate correct accept and reject from a block that ignores busy or orders the write after the request. Payload and status are read both by index and through the aliases, under several requester ids and at the first and last CPU, which exposes swapped arrays, wrong strides and alias decode taken from the address instead of the requester. Status writes with junk in the non-busy bits, vector writes with high bits set, and writes to read-only or unmapped offsets confirm that only the defined bits take effect.

// File: rtl/cpu_irq_mailbox_pkg.sv
`timescale 1ns/1ps
package cpu_irq_mailbox_pkg;

  // Register target chosen by the offset decoder.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA0,
    SEL_DATA1,
    SEL_STATUS,
    SEL_VECTOR
  } sel_e;

  // Position of the busy flag inside a status word.
  localparam int BUSY_BIT = 5;

endpackage

// File: rtl/mbx_reg_decode.sv
`timescale 1ns/1ps
module mbx_reg_decode
  import cpu_irq_mailbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  self_i,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [31:0] SPAN    = 32'(NUM_CPU * 8);
  localparam logic [31:0] D1_BASE = SPAN;
  localparam logic [31:0] ST_BASE = 2 * SPAN;
  localparam logic [31:0] AL_BASE = 3 * SPAN;
  localparam logic [31:0] N_WORDS = 32'(NUM_CPU);

  logic [31:0] off;
  logic [31:0] word;

  always_comb begin
    off   = 32'(addr_i);
    word  = off >> 3;
    sel_o = SEL_NONE;
    idx_o = '0;
    if (off[2:0] == 3'b000) begin
      if (off < D1_BASE) begin
        sel_o = SEL_DATA0;
        idx_o = IDX_W'(word);
      end else if (off < ST_BASE) begin
        sel_o = SEL_DATA1;
        idx_o = IDX_W'(word - N_WORDS);
      end else if (off < AL_BASE) begin
        sel_o = SEL_STATUS;
        idx_o = IDX_W'(word - 2 * N_WORDS);
      end else if (off == AL_BASE) begin
        sel_o = SEL_DATA0;
        idx_o = self_i;
      end else if (off == AL_BASE + 32'd8) begin
        sel_o = SEL_DATA1;
        idx_o = self_i;
      end else if (off == AL_BASE + 32'd16) begin
        sel_o = SEL_STATUS;
        idx_o = self_i;
      end else if (off == AL_BASE + 32'd24) begin
        sel_o = SEL_VECTOR;
      end
    end
  end

endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
  parameter int SRC_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we_i,
  input  logic              sw_busy_i,
  input  logic              accept_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  output logic              busy_eff_o,
  output logic              busy_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [DATA_W-1:0] d1_o
);

  logic              busy_q, busy_d, busy_en;
  logic [SRC_W-1:0]  src_q;
  logic [DATA_W-1:0] d0_q, d1_q;

  // Software write is ordered ahead of an arriving message.
  always_comb begin
    busy_eff_o = sw_we_i ? sw_busy_i : busy_q;
    busy_d     = accept_i | busy_eff_o;
    busy_en    = accept_i | sw_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else if (accept_i) begin
      src_q <= src_i;
      d0_q  <= d0_i;
      d1_q  <= d1_i;
    end
  end

  assign busy_o = busy_q;
  assign src_o  = src_q;
  assign d0_o   = d0_q;
  assign d1_o   = d1_q;

endmodule

// File: rtl/mbx_read_mux.sv
`timescale 1ns/1ps
module mbx_read_mux
  import cpu_irq_mailbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int IDX_W   = 5,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6
) (
  input  sel_e                             sel_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [NUM_CPU-1:0]               busy_i,
  input  logic [NUM_CPU-1:0][SRC_W-1:0]    src_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0]   d0_i,
  input  logic [NUM_CPU-1:0][DATA_W-1:0]   d1_i,
  input  logic [VEC_W-1:0]                 vec_i,
  output logic [DATA_W-1:0]                rdata_o
);

  always_comb begin
    unique case (sel_i)
      SEL_DATA0:  rdata_o = d0_i[idx_i];
      SEL_DATA1:  rdata_o = d1_i[idx_i];
      SEL_STATUS: rdata_o = (DATA_W'(busy_i[idx_i]) << BUSY_BIT) | DATA_W'(src_i[idx_i]);
      SEL_VECTOR: rdata_o = DATA_W'(vec_i);
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mbx_post.sv
`timescale 1ns/1ps
module mbx_post #(
  parameter int CPU_W = 5,
  parameter int VEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_wdata_i,
  input  logic             accept_i,
  input  logic [CPU_W-1:0] cpu_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             post_valid_o,
  output logic [CPU_W-1:0] post_cpu_o,
  output logic [VEC_W-1:0] post_vec_o
);

  logic [VEC_W-1:0] vec_q;
  logic             pv_q;
  logic [CPU_W-1:0] pcpu_q;
  logic [VEC_W-1:0] pvec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_we_i) begin
      vec_q <= vec_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
    end else begin
      pv_q <= accept_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcpu_q <= '0;
      pvec_q <= '0;
    end else if (accept_i) begin
      pcpu_q <= cpu_i;
      pvec_q <= vec_q;
    end
  end

  assign vec_o        = vec_q;
  assign post_valid_o = pv_q;
  assign post_cpu_o   = pcpu_q;
  assign post_vec_o   = pvec_q;

endmodule

// File: rtl/cpu_irq_mailbox.sv
`timescale 1ns/1ps
module cpu_irq_mailbox
  import cpu_irq_mailbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 12,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CPU_W-1:0]  in_cpu,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data0,
  input  logic [DATA_W-1:0] in_data1,
  output logic              in_ready,
  output logic              post_valid,
  output logic [CPU_W-1:0]  post_cpu,
  output logic [VEC_W-1:0]  post_vec,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);

  sel_e                            sel;
  logic [CPU_W-1:0]                idx;
  logic                            wr_go, rd_go, vec_we;
  logic [NUM_CPU-1:0]              sw_we_vec, accept_vec, busy_eff_vec, busy_vec;
  logic [NUM_CPU-1:0][SRC_W-1:0]   src_arr;
  logic [NUM_CPU-1:0][DATA_W-1:0]  d0_arr, d1_arr;
  logic [VEC_W-1:0]                vec_q;
  logic [DATA_W-1:0]               rdata_d, rdata_q;
  logic                            rvalid_q;
  logic                            wdata_unused;

  assign wr_go  = reg_en & reg_we;
  assign rd_go  = reg_en & ~reg_we;
  assign vec_we = wr_go & (sel == SEL_VECTOR);
  assign wdata_unused = ^reg_wdata;

  mbx_reg_decode #(
    .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .IDX_W(CPU_W)
  ) u_dec (
    .addr_i(reg_addr), .self_i(reg_cpu), .sel_o(sel), .idx_o(idx)
  );

  assign in_ready = in_valid & ~busy_eff_vec[in_cpu];

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    assign sw_we_vec[g]  = wr_go & (sel == SEL_STATUS) & (idx == CPU_W'(g));
    assign accept_vec[g] = in_ready & (in_cpu == CPU_W'(g));

    mbx_slot #(
      .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .sw_we_i(sw_we_vec[g]), .sw_busy_i(reg_wdata[BUSY_BIT]),
      .accept_i(accept_vec[g]),
      .src_i(in_src), .d0_i(in_data0), .d1_i(in_data1),
      .busy_eff_o(busy_eff_vec[g]), .busy_o(busy_vec[g]),
      .src_o(src_arr[g]), .d0_o(d0_arr[g]), .d1_o(d1_arr[g])
    );
  end

  mbx_read_mux #(
    .NUM_CPU(NUM_CPU), .IDX_W(CPU_W), .SRC_W(SRC_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) u_rmux (
    .sel_i(sel), .idx_i(idx), .busy_i(busy_vec), .src_i(src_arr),
    .d0_i(d0_arr), .d1_i(d1_arr), .vec_i(vec_q), .rdata_o(rdata_d)
  );

  mbx_post #(
    .CPU_W(CPU_W), .VEC_W(VEC_W)
  ) u_post (
    .clk(clk), .rst_n(rst_n),
    .vec_we_i(vec_we), .vec_wdata_i(reg_wdata[VEC_W-1:0]),
    .accept_i(in_ready), .cpu_i(in_cpu),
    .vec_o(vec_q), .post_valid_o(post_valid), .post_cpu_o(post_cpu), .post_vec_o(post_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_go) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = rdata_q;

endmodule

// File: rtl/cpu_irq_mailbox_chk.sv
`timescale 1ns/1ps
module cpu_irq_mailbox_chk #(
  parameter int NUM_CPU = 32,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [CPU_W-1:0]   in_cpu,
  input logic               in_ready,
  input logic               post_valid,
  input logic [CPU_W-1:0]   post_cpu,
  input logic [VEC_W-1:0]   post_vec,
  input logic               reg_en,
  input logic               reg_we,
  input logic               reg_rvalid,
  input logic [NUM_CPU-1:0] busy_vec,
  input logic [NUM_CPU-1:0] sw_we_vec,
  input logic [VEC_W-1:0]   vec_q
);

  // R2
  post_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (post_valid && post_cpu == $past(in_cpu)));

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy_vec[$past(in_cpu)]);

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  // R3
  busy_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy_vec[in_cpu] && !sw_we_vec[in_cpu]) |-> !in_ready);

  // R3
  no_spurious_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !post_valid);

  // R8
  post_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (post_vec == $past(vec_q)));

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we) |=> reg_rvalid);

  // R10
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && !reg_we) |=> !reg_rvalid);

endmodule

bind cpu_irq_mailbox cpu_irq_mailbox_chk #(
  .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cpu(in_cpu),
  .in_ready(in_ready), .post_valid(post_valid), .post_cpu(post_cpu),
  .post_vec(post_vec), .reg_en(reg_en), .reg_we(reg_we),
  .reg_rvalid(reg_rvalid), .busy_vec(busy_vec), .sw_we_vec(sw_we_vec),
  .vec_q(vec_q)
);

// File: tb/sim_cpu_irq_mailbox.sv
`timescale 1ns/1ps
module sim_cpu_irq_mailbox;

  localparam int A_D0 = 'h000, A_D1 = 'h100, A_ST = 'h200;
  localparam int A_AD0 = 'h300, A_AD1 = 'h308, A_AST = 'h310, A_VEC = 'h318;

  logic        clk, rst_n;
  logic        in_valid;
  logic [4:0]  in_cpu, in_src;
  logic [63:0] in_data0, in_data1;
  logic        in_ready, post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;
  logic        reg_en, reg_we;
  logic [11:0] reg_addr;
  logic [4:0]  reg_cpu;
  logic [63:0] reg_wdata;
  logic        reg_rvalid;
  logic [63:0] reg_rdata;

  cpu_irq_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cpu(in_cpu), .in_src(in_src),
    .in_data0(in_data0), .in_data1(in_data1), .in_ready(in_ready),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_cpu(reg_cpu),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model built from the requirements
  logic        mbusy [32];
  logic [4:0]  msrc  [32];
  logic [63:0] md0   [32];
  logic [63:0] md1   [32];
  logic [5:0]  mvec;

  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(int a, int c);
    if (a % 8 != 0) return 64'd0;
    if (a < A_D1) return md0[a / 8];
    if (a < A_ST) return md1[(a - A_D1) / 8];
    if (a < A_AD0) return {58'd0, mbusy[(a - A_ST) / 8], msrc[(a - A_ST) / 8]};
    if (a == A_AD0) return md0[c];
    if (a == A_AD1) return md1[c];
    if (a == A_AST) return {58'd0, mbusy[c], msrc[c]};
    if (a == A_VEC) return {58'd0, mvec};
    return 64'd0;
  endfunction

  function automatic void mwrite(int a, int c, logic [63:0] d);
    if (a % 8 != 0) return;
    if (a >= A_ST && a < A_AD0) mbusy[(a - A_ST) / 8] = d[5];
    else if (a == A_AST) mbusy[c] = d[5];
    else if (a == A_VEC) mvec = d[5:0];
  endfunction

  task automatic idle_inputs();
    in_valid = 0; in_cpu = 0; in_src = 0; in_data0 = 0; in_data1 = 0;
    reg_en = 0; reg_we = 0; reg_addr = 0; reg_cpu = 0; reg_wdata = 0;
  endtask

  // message, optionally paired with a register write in the same cycle
  task automatic req_wr(int c, int s, logic [63:0] a, logic [63:0] b,
                        bit do_wr, int wa, int wc, logic [63:0] wd, string tag);
    logic exp;
    logic [5:0] evec;
    @(negedge clk);
    evec = mvec;
    if (do_wr) mwrite(wa, wc, wd);
    exp = !mbusy[c];
    in_valid = 1; in_cpu = 5'(c); in_src = 5'(s); in_data0 = a; in_data1 = b;
    if (do_wr) begin
      reg_en = 1; reg_we = 1; reg_addr = 12'(wa); reg_cpu = 5'(wc); reg_wdata = wd;
    end
    #1;
    chk(in_ready == exp, {tag, " ready"}, 64'(in_ready), 64'(exp));
    @(negedge clk);
    idle_inputs();
    chk(post_valid == exp, {tag, " post_valid"}, 64'(post_valid), 64'(exp));
    if (exp) begin
      chk(post_cpu == 5'(c), {tag, " post_cpu"}, 64'(post_cpu), 64'(c));
      chk(post_vec == evec, {tag, " post_vec"}, 64'(post_vec), 64'(evec));
      mbusy[c] = 1; msrc[c] = 5'(s); md0[c] = a; md1[c] = b;
    end
  endtask

  task automatic send(int c, int s, logic [63:0] a, logic [63:0] b, string tag);
    req_wr(c, s, a, b, 0, 0, 0, 64'd0, tag);
  endtask

  task automatic wr(int a, int c, logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = 12'(a); reg_cpu = 5'(c); reg_wdata = d;
    mwrite(a, c, d);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rd(int a, int c, string tag);
    exp_t e;
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = 12'(a); reg_cpu = 5'(c);
    e.val = mread(a, c);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (sb.size() == 0) begin
        chk(0, "R10 unexpected rvalid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(reg_rdata == e.val, e.tag, reg_rdata, e.val);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mbusy[i] = 0; msrc[i] = 0; md0[i] = 0; md1[i] = 0;
    end
    mvec = 0;
    idle_inputs();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(post_valid == 0, "R1 post_valid", 64'(post_valid), 0);
    chk(reg_rvalid == 0, "R1 rvalid", 64'(reg_rvalid), 0);
    chk(in_ready == 0, "R1 ready", 64'(in_ready), 0);
    rd(A_ST + 0, 0, "R1 status cpu0");
    rd(A_ST + 31 * 8, 0, "R1 status cpu31");
    rd(A_D0 + 12 * 8, 0, "R1 data0 cpu12");
    rd(A_VEC, 0, "R1 vector");

    // R2 accept into a free mailbox
    send(3, 7, 64'hA0A0_0000_0000_0003, 64'hB0B0_0000_0000_0003, "R2 cpu3");
    // R8 vector register keeps bits 5:0
    wr(A_VEC, 0, 64'hFFFF_FFFF_FFFF_FFEA);
    rd(A_VEC, 0, "R8 vector readback");
    send(5, 31, 64'hC5C5_1234_5678_9ABC, 64'hD5D5_0FED_CBA9_8765, "R8 posted vector");
    // R3 busy mailbox refuses and keeps data
    send(3, 1, 64'hEEEE_EEEE_EEEE_EEEE, 64'hFFFF_FFFF_FFFF_FFFF, "R3 busy cpu3");
    rd(A_D0 + 3 * 8, 0, "R3 data0 kept");
    rd(A_ST + 3 * 8, 0, "R3 source kept");
    // R4 indexed payload
    rd(A_D1 + 3 * 8, 0, "R4 data1 cpu3");
    rd(A_D0 + 5 * 8, 0, "R4 data0 cpu5");
    rd(A_D1 + 5 * 8, 0, "R4 data1 cpu5");
    // R5 status layout
    rd(A_ST + 5 * 8, 0, "R5 status cpu5");
    rd(A_ST + 4 * 8, 0, "R5 status free cpu4");
    // R7 alias by requester
    rd(A_AD0, 5, "R7 alias data0 cpu5");
    rd(A_AD1, 5, "R7 alias data1 cpu5");
    rd(A_AST, 5, "R7 alias status cpu5");
    rd(A_AST, 3, "R7 alias status cpu3");
    rd(A_AD0, 9, "R7 alias data0 cpu9");
    // R6 release via status write, other bits ignored
    wr(A_ST + 3 * 8, 0, 64'hFFFF_FFFF_FFFF_FFDF);
    rd(A_ST + 3 * 8, 0, "R6 status after release");
    send(3, 2, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R6 accept after release");
    rd(A_D0 + 3 * 8, 0, "R6 new data0");
    // R6 software-set busy blocks
    wr(A_ST + 10 * 8, 0, 64'h20);
    rd(A_ST + 10 * 8, 0, "R6 status set busy");
    send(10, 4, 64'h10, 64'h11, "R6 refused after set");
    // R9 same-cycle ordering
    req_wr(10, 6, 64'hAAAA, 64'hBBBB, 1, A_AST, 10, 64'h0, "R9 release same cycle");
    rd(A_ST + 10 * 8, 0, "R9 status cpu10");
    req_wr(20, 9, 64'h2020, 64'h2121, 1, A_ST + 20 * 8, 0, 64'h20, "R9 lock same cycle");
    rd(A_D0 + 20 * 8, 0, "R9 data0 cpu20 untouched");
    req_wr(7, 12, 64'h7777, 64'h7070, 1, A_ST + 8 * 8, 0, 64'h20, "R9 other slot");
    rd(A_ST + 8 * 8, 0, "R9 status cpu8");
    // R10 read-only and unmapped offsets
    wr(A_D0 + 3 * 8, 0, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(A_D1 + 5 * 8, 0, 64'hDEAD_BEEF_DEAD_BEEF);
    wr('h3F8, 0, 64'h3F);
    rd(A_D0 + 3 * 8, 0, "R10 data0 not writable");
    rd(A_D1 + 5 * 8, 0, "R10 data1 not writable");
    rd(A_ST + 3 * 8 + 4, 0, "R10 misaligned read");
    rd('h3F8, 0, "R10 unmapped read");
    rd('h320, 0, "R10 past alias read");
    rd(A_VEC, 0, "R10 vector unchanged");
    // boundaries: first and last CPU
    send(31, 19, 64'h3131_3131_3131_3131, 64'h1F1F, "R2 cpu31");
    send(0, 0, 64'h0F0F, 64'hF0F0, "R2 cpu0");
    rd(A_ST + 31 * 8, 0, "R5 status cpu31");
    rd(A_AST, 31, "R7 alias status cpu31");
    rd(A_AD1, 0, "R7 alias data1 cpu0");
    send(31, 2, 64'h0, 64'h0, "R3 busy cpu31");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R10 reads outstanding", 64'(sb.size()), 0);
    finish_run();
  end

endmodule